// File: doc/BRIEF.md
# Function Configuration Header Register File

This block holds the standard 64-byte configuration header of one device function: the identity fields, command and status, cache line size and latency timer, interrupt routing bytes, six base address registers (BARs) and an expansion ROM base register. A configuration master reads or writes it one access at a time, with a byte offset and a size of 1, 2 or 4 bytes. Accesses outside the header, of an unsupported size or not aligned to their size are refused and flagged. The reset contents of every field come from parameters.

Each BAR keeps its space type bits fixed and answers the all-ones write used by enumeration software to discover its size. Once software has programmed a non-zero base, the BAR opens an address window of its configured size. The window sits above a separate space base for I/O or memory. A decode port compares a given address against all open windows and reports which one it falls in and at what offset.

Top module: `cfg_func_header`

## Requirements
- R1: An access whose size is not 1, 2 or 4 bytes raises `acc_err` in the cycle after the request, changes no register and returns zero on `rd_data`.
- R2: An access at byte offset 0x40 or above raises `acc_err`, changes no register and reads back zero.
- R3: An access whose offset is not a multiple of its size raises `acc_err` and is otherwise ignored.
- R4: A valid read returns, in the cycle after the request, the addressed bytes right-justified and little-endian. The dword layout is: 0x00 device(31:16)/vendor(15:0); 0x04 status/command; 0x08 class(31:24), subclass, programming interface, revision(7:0); 0x0C self-test(31:24), header type, latency timer, cache line size(7:0); 0x10-0x24 BAR0-BAR5; 0x28 card information pointer; 0x2C subsystem id(31:16)/subsystem vendor; 0x30 ROM base; 0x34 and 0x38 zero; 0x3C maximum latency(31:24), minimum grant, interrupt pin, interrupt line(7:0). After reset every field holds its parameter value.
- R5: BAR bit 0 selects I/O (1) or memory (0). The low 2 bits of an I/O BAR and the low 4 bits of a memory BAR never change.
- R6: A 4-byte write of 0xFFFFFFFF to a BAR sets its writable bits to the inverse of (size - 1); a BAR with size 0 then reads back only its type bits.
- R7: Any other 4-byte BAR write replaces only the writable bits. 1- and 2-byte writes to BARs are ignored.
- R8: A 4-byte write of 0xFFFFFFFE to the ROM base register makes it read 0xFFFFFFFF; any other 4-byte value is stored as written.
- R9: Interrupt line (0x3C), cache line size (0x0C) and latency timer (0x0D) take 1-byte writes from `acc_wdata[7:0]`. Writes to the identity, class, revision, interrupt pin, grant and latency limit bytes have no effect.
- R10: The command register at 0x04 is written from `acc_wdata[15:0]` by a 2-byte or 4-byte write at 0x04, and such writes leave status unchanged.
- R11: A BAR with non-zero writable bits and non-zero size decodes the window [writable bits + space base, + size); the space base is the I/O or memory parameter by the type bit. One cycle after `dec_addr` is applied, `dec_hit` carries bit i for BAR i and `dec_offset` the address minus the window base, or zero with no hit.
- R12: When windows overlap, only the lowest-numbered hitting BAR is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Configuration access request, one cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_size | input | 3 | Access size in bytes |
| acc_offset | input | 8 | Byte offset into the header |
| acc_wdata | input | 32 | Write data, right-justified |
| rd_data | output | 32 | Read data, valid the cycle after a read, zero otherwise |
| acc_err | output | 1 | Pulses the cycle after a refused access |
| dec_addr | input | 32 | Address to decode against the BAR windows |
| dec_hit | output | 6 | One-hot window hit, registered |
| dec_offset | output | 32 | Offset within the hit window, registered |

## Verification
On every cycle the assertions check that type bits of each BAR hold still, that a refused access returns zero data, that high-offset accesses are refused, that ROM sizing and command writes land, and that the hit vector is never multi-hot. The sizing masks per BAR, the little-endian byte assembly, the ignoring of writes to read-only fields and to BARs by narrow accesses, the window placement above each space base and the lowest-index choice on overlap are only shown by the bench scenarios, which compare read-back and decode results against values worked out from the parameters.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int NUM_BARS  = 6;
  localparam int DW        = 32;
  localparam int OFS_W     = 8;
  localparam int HDR_BYTES = 64;
  localparam int HDR_DW    = HDR_BYTES / 4;

  localparam logic [OFS_W-1:0] OFS_CMD     = 8'h04;
  localparam logic [OFS_W-1:0] OFS_CLS     = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_LAT     = 8'h0D;
  localparam logic [OFS_W-1:0] OFS_BAR0    = 8'h10;
  localparam logic [OFS_W-1:0] OFS_ROM     = 8'h30;
  localparam logic [OFS_W-1:0] OFS_INTLINE = 8'h3C;

  localparam logic [DW-1:0] ROM_SIZE_REQ = 32'hFFFF_FFFE;

  // Read-only low bits of a BAR, chosen by its space type bit.
  function automatic logic [DW-1:0] bar_ro_mask(input logic is_io);
    return is_io ? 32'h0000_0003 : 32'h0000_000F;
  endfunction

  // Mask a right-justified read value down to the access width.
  function automatic logic [DW-1:0] size_mask(input logic [2:0] sz);
    case (sz)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cfg_acc_check.sv
module cfg_acc_check
  import cfg_hdr_pkg::*;
(
  input  logic             valid,
  input  logic [2:0]       size,
  input  logic [OFS_W-1:0] offset,
  output logic             good,
  output logic             bad
);
  logic size_ok, align_ok, range_ok;

  always_comb begin
    size_ok  = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    case (size)
      3'd2:    align_ok = (offset[0] == 1'b0);
      3'd4:    align_ok = (offset[1:0] == 2'b00);
      default: align_ok = 1'b1;
    endcase
    range_ok = (offset < OFS_W'(HDR_BYTES));
    good     = valid && size_ok && align_ok && range_ok;
    bad      = valid && !(size_ok && align_ok && range_ok);
  end
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import cfg_hdr_pkg::*;
#(
  parameter logic [DW-1:0] INIT      = '0,
  parameter logic [DW-1:0] WIN_SIZE  = '0,
  parameter logic [DW-1:0] IO_BASE   = '0,
  parameter logic [DW-1:0] MEM_BASE  = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] addr,
  output logic [DW-1:0] bar_q,
  output logic          hit,
  output logic [DW-1:0] win_ofs
);
  localparam logic          IS_IO     = INIT[0];
  localparam logic [DW-1:0] RO_MASK   = bar_ro_mask(IS_IO);
  localparam logic [DW-1:0] SIZE_BITS = ~(WIN_SIZE - 32'd1) & ~RO_MASK;
  localparam logic [DW-1:0] SPACE     = IS_IO ? IO_BASE : MEM_BASE;

  always_ff @(posedge clk) begin
    if (rst) begin
      bar_q <= INIT;
    end else if (wr_en) begin
      if (wdata == '1) bar_q <= SIZE_BITS | (bar_q & RO_MASK);
      else             bar_q <= (wdata & ~RO_MASK) | (bar_q & RO_MASK);
    end
  end

  logic [DW-1:0] base_field, delta;
  logic          open_win;

  always_comb begin
    base_field = bar_q & ~RO_MASK;
    open_win   = (base_field != '0) && (WIN_SIZE != '0);
    delta      = addr - (base_field + SPACE);
    hit        = open_win && (delta < WIN_SIZE);
    win_ofs    = delta;
  end

  // R5: the space type bits are fixed after reset
  a_r5_type_bits_fixed: assert property (@(posedge clk) disable iff (rst)
    $stable(bar_q & RO_MASK));
endmodule

// File: rtl/cfg_win_pick.sv
module cfg_win_pick
  import cfg_hdr_pkg::*;
(
  input  logic [NUM_BARS-1:0]        hit,
  input  logic [NUM_BARS*DW-1:0]     ofs_flat,
  output logic [NUM_BARS-1:0]        hit_sel,
  output logic [DW-1:0]              ofs_sel
);
  always_comb begin
    hit_sel = '0;
    ofs_sel = '0;
    for (int i = NUM_BARS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_sel = '0;
        hit_sel[i] = 1'b1;
        ofs_sel = ofs_flat[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/cfg_func_header.sv
module cfg_func_header
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'hABCD,
  parameter logic [15:0] DEVICE_ID   = 16'h0123,
  parameter logic [15:0] CMD_INIT    = 16'h0000,
  parameter logic [15:0] STATUS_VAL  = 16'h0290,
  parameter logic [7:0]  REVISION    = 8'h02,
  parameter logic [7:0]  PROG_IF     = 8'h00,
  parameter logic [7:0]  SUBCLASS    = 8'h80,
  parameter logic [7:0]  CLASS_CODE  = 8'h05,
  parameter logic [7:0]  CLS_INIT    = 8'h00,
  parameter logic [7:0]  LAT_INIT    = 8'h00,
  parameter logic [7:0]  HDR_TYPE    = 8'h00,
  parameter logic [7:0]  SELF_TEST   = 8'h00,
  parameter logic [31:0] CIS_PTR     = 32'h0000_0000,
  parameter logic [15:0] SUB_VENDOR  = 16'h5A5A,
  parameter logic [15:0] SUB_ID      = 16'hC3C3,
  parameter logic [31:0] ROM_INIT    = 32'h0000_0000,
  parameter logic [7:0]  IRQ_LINE    = 8'h0A,
  parameter logic [7:0]  IRQ_PIN     = 8'h01,
  parameter logic [7:0]  MIN_GRANT   = 8'h04,
  parameter logic [7:0]  MAX_LAT     = 8'h10,
  parameter logic [NUM_BARS*DW-1:0] BAR_INIT =
    {32'h0, 32'h1, 32'h0, 32'h8, 32'h1, 32'h0},
  parameter logic [NUM_BARS*DW-1:0] BAR_SIZE =
    {32'h0, 32'h20, 32'h0, 32'h1_0000, 32'h100, 32'h1000},
  parameter logic [DW-1:0] IO_BASE   = 32'h0800_0000,
  parameter logic [DW-1:0] MEM_BASE  = 32'h4000_0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [2:0]          acc_size,
  input  logic [OFS_W-1:0]    acc_offset,
  input  logic [DW-1:0]       acc_wdata,
  output logic [DW-1:0]       rd_data,
  output logic                acc_err,
  input  logic [DW-1:0]       dec_addr,
  output logic [NUM_BARS-1:0] dec_hit,
  output logic [DW-1:0]       dec_offset
);
  logic good, bad;

  cfg_acc_check u_chk (
    .valid  (acc_valid),
    .size   (acc_size),
    .offset (acc_offset),
    .good   (good),
    .bad    (bad)
  );

  logic wr_b, wr_h, wr_w, rd_ok;
  assign wr_b  = good && acc_write && (acc_size == 3'd1);
  assign wr_h  = good && acc_write && (acc_size == 3'd2);
  assign wr_w  = good && acc_write && (acc_size == 3'd4);
  assign rd_ok = good && !acc_write;

  // Writable scalar fields
  logic [15:0] cmd_q;
  logic [7:0]  cls_q, lat_q, irq_line_q;
  logic [31:0] rom_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= CMD_INIT;
      cls_q      <= CLS_INIT;
      lat_q      <= LAT_INIT;
      irq_line_q <= IRQ_LINE;
      rom_q      <= ROM_INIT;
    end else begin
      if ((wr_h || wr_w) && acc_offset == OFS_CMD) cmd_q <= acc_wdata[15:0];
      if (wr_b && acc_offset == OFS_CLS)     cls_q      <= acc_wdata[7:0];
      if (wr_b && acc_offset == OFS_LAT)     lat_q      <= acc_wdata[7:0];
      if (wr_b && acc_offset == OFS_INTLINE) irq_line_q <= acc_wdata[7:0];
      if (wr_w && acc_offset == OFS_ROM)
        rom_q <= (acc_wdata == ROM_SIZE_REQ) ? '1 : acc_wdata;
    end
  end

  // Base address registers and their windows
  logic [NUM_BARS*DW-1:0] bar_flat, ofs_flat;
  logic [NUM_BARS-1:0]    bar_hit;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    logic sel;
    assign sel = wr_w && (acc_offset == OFS_BAR0 + OFS_W'(4 * i));
    cfg_bar_slot #(
      .INIT     (BAR_INIT[i*DW +: DW]),
      .WIN_SIZE (BAR_SIZE[i*DW +: DW]),
      .IO_BASE  (IO_BASE),
      .MEM_BASE (MEM_BASE)
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (sel),
      .wdata   (acc_wdata),
      .addr    (dec_addr),
      .bar_q   (bar_flat[i*DW +: DW]),
      .hit     (bar_hit[i]),
      .win_ofs (ofs_flat[i*DW +: DW])
    );
  end

  logic [NUM_BARS-1:0] hit_sel;
  logic [DW-1:0]       ofs_sel;

  cfg_win_pick u_pick (
    .hit      (bar_hit),
    .ofs_flat (ofs_flat),
    .hit_sel  (hit_sel),
    .ofs_sel  (ofs_sel)
  );

  // Header view, one dword per row
  logic [DW-1:0] hdr_dw [HDR_DW];
  always_comb begin
    for (int d = 0; d < HDR_DW; d++) hdr_dw[d] = '0;
    hdr_dw[0]  = {DEVICE_ID, VENDOR_ID};
    hdr_dw[1]  = {STATUS_VAL, cmd_q};
    hdr_dw[2]  = {CLASS_CODE, SUBCLASS, PROG_IF, REVISION};
    hdr_dw[3]  = {SELF_TEST, HDR_TYPE, lat_q, cls_q};
    for (int b = 0; b < NUM_BARS; b++) hdr_dw[4 + b] = bar_flat[b*DW +: DW];
    hdr_dw[10] = CIS_PTR;
    hdr_dw[11] = {SUB_ID, SUB_VENDOR};
    hdr_dw[12] = rom_q;
    hdr_dw[15] = {MAX_LAT, MIN_GRANT, IRQ_PIN, irq_line_q};
  end

  logic [DW-1:0] rd_val;
  assign rd_val = (hdr_dw[acc_offset[5:2]] >> {acc_offset[1:0], 3'b000})
                  & size_mask(acc_size);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      acc_err    <= 1'b0;
      dec_hit    <= '0;
      dec_offset <= '0;
    end else begin
      rd_data    <= rd_ok ? rd_val : '0;
      acc_err    <= bad;
      dec_hit    <= hit_sel;
      dec_offset <= ofs_sel;
    end
  end

  // R2: the device-specific region is refused
  a_r2_upper_refused: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_offset >= OFS_W'(HDR_BYTES)) |=> acc_err);

  // R1: a refused access never returns data
  a_r1_err_reads_zero: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> (rd_data == '0));

  // R8: ROM sizing request reads back all ones
  a_r8_rom_sizing: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_size == 3'd4 && acc_offset == OFS_ROM
     && acc_wdata == ROM_SIZE_REQ) |=> (rom_q == '1));

  // R10: a halfword command write lands
  a_r10_cmd_write: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_size == 3'd2 && acc_offset == OFS_CMD)
    |=> (cmd_q == $past(acc_wdata[15:0])));

  // R12: at most one window is reported
  a_r12_single_hit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dec_hit));
endmodule

// File: tb/sim_cfg_func_header.sv
module sim_cfg_func_header;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [2:0]  acc_size  = 3'd4;
  logic [7:0]  acc_offset = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic        acc_err;
  logic [31:0] dec_addr = '0;
  logic [5:0]  dec_hit;
  logic [31:0] dec_offset;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_func_header u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .acc_err(acc_err), .dec_addr(dec_addr),
    .dec_hit(dec_hit), .dec_offset(dec_offset)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sz, input logic [7:0] ofs,
                    input logic [31:0] exp, input logic exp_err, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_size = sz; acc_offset = ofs;
    @(negedge clk);
    acc_valid = 1'b0;
    check({tag, " data"}, rd_data, exp);
    check({tag, " err"}, {31'd0, acc_err}, {31'd0, exp_err});
  endtask

  task automatic wr(input logic [2:0] sz, input logic [7:0] ofs,
                    input logic [31:0] data, input logic exp_err, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_size = sz; acc_offset = ofs;
    acc_wdata = data;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    check({tag, " err"}, {31'd0, acc_err}, {31'd0, exp_err});
  endtask

  task automatic dec(input logic [31:0] addr, input logic [5:0] exp_hit,
                     input logic [31:0] exp_ofs, input string tag);
    @(negedge clk);
    dec_addr = addr;
    @(negedge clk);
    check({tag, " hit"}, {26'd0, dec_hit}, {26'd0, exp_hit});
    check({tag, " ofs"}, dec_offset, exp_ofs);
  endtask

  task automatic t_reset_state();
    check("R4 reset rd_data", rd_data, 32'h0);
    check("R1 reset err", {31'd0, acc_err}, 32'h0);
    check("R11 reset hit", {26'd0, dec_hit}, 32'h0);
    rd(3'd4, 8'h00, 32'h0123_ABCD, 1'b0, "R4 id dword");
    rd(3'd4, 8'h04, 32'h0290_0000, 1'b0, "R4 status/cmd");
    rd(3'd4, 8'h08, 32'h0580_0002, 1'b0, "R4 class dword");
    rd(3'd1, 8'h02, 32'h0000_0023, 1'b0, "R4 byte lane 2");
    rd(3'd2, 8'h2E, 32'h0000_C3C3, 1'b0, "R4 subsystem id half");
    rd(3'd4, 8'h3C, 32'h1004_010A, 1'b0, "R4 irq dword");
    rd(3'd4, 8'h14, 32'h0000_0001, 1'b0, "R5 BAR1 io type");
    rd(3'd4, 8'h34, 32'h0, 1'b0, "R4 reserved dword");
  endtask

  task automatic t_refused();
    rd(3'd3, 8'h00, 32'h0, 1'b1, "R1 size 3 read");
    wr(3'd0, 8'h3C, 32'h55, 1'b1, "R1 size 0 write");
    rd(3'd1, 8'h3C, 32'h0A, 1'b0, "R1 size 0 write ignored");
    rd(3'd4, 8'h40, 32'h0, 1'b1, "R2 offset 0x40 read");
    rd(3'd1, 8'hFF, 32'h0, 1'b1, "R2 offset 0xFF read");
    wr(3'd4, 8'h44, 32'hDEAD_BEEF, 1'b1, "R2 offset 0x44 write");
    rd(3'd2, 8'h01, 32'h0, 1'b1, "R3 half misaligned");
    rd(3'd4, 8'h02, 32'h0, 1'b1, "R3 word misaligned");
    wr(3'd2, 8'h05, 32'hFFFF, 1'b1, "R3 misaligned cmd write");
    rd(3'd4, 8'h04, 32'h0290_0000, 1'b0, "R3 cmd untouched");
  endtask

  task automatic t_byte_fields();
    wr(3'd1, 8'h3C, 32'h77, 1'b0, "R9 irq line");
    wr(3'd1, 8'h0C, 32'h10, 1'b0, "R9 cache line");
    wr(3'd1, 8'h0D, 32'h40, 1'b0, "R9 latency timer");
    rd(3'd4, 8'h0C, 32'h0000_4010, 1'b0, "R9 timing dword");
    wr(3'd1, 8'h3D, 32'hEE, 1'b0, "R9 pin write");
    wr(3'd1, 8'h3E, 32'hEE, 1'b0, "R9 grant write");
    wr(3'd1, 8'h3F, 32'hEE, 1'b0, "R9 maxlat write");
    wr(3'd1, 8'h08, 32'h99, 1'b0, "R9 revision write");
    wr(3'd1, 8'h0B, 32'h99, 1'b0, "R9 class write");
    wr(3'd4, 8'h00, 32'h1111_1111, 1'b0, "R9 id write");
    rd(3'd4, 8'h3C, 32'h1004_0177, 1'b0, "R9 ro irq bytes kept");
    rd(3'd4, 8'h08, 32'h0580_0002, 1'b0, "R9 ro class kept");
    rd(3'd4, 8'h00, 32'h0123_ABCD, 1'b0, "R9 ro id kept");
  endtask

  task automatic t_command();
    wr(3'd2, 8'h04, 32'h0000_0147, 1'b0, "R10 half cmd");
    rd(3'd4, 8'h04, 32'h0290_0147, 1'b0, "R10 half cmd readback");
    wr(3'd4, 8'h04, 32'hFFFF_0006, 1'b0, "R10 word cmd");
    rd(3'd4, 8'h04, 32'h0290_0006, 1'b0, "R10 status unchanged");
    wr(3'd2, 8'h06, 32'h0000_FFFF, 1'b0, "R10 status write");
    rd(3'd2, 8'h06, 32'h0000_0290, 1'b0, "R10 status still set");
  endtask

  task automatic t_bar_sizing();
    for (int i = 0; i < 6; i++)
      wr(3'd4, 8'h10 + 8'(4 * i), 32'hFFFF_FFFF, 1'b0, "R6 size request");
    rd(3'd4, 8'h10, 32'hFFFF_F000, 1'b0, "R6 BAR0 mem 4K");
    rd(3'd4, 8'h14, 32'hFFFF_FF01, 1'b0, "R6 BAR1 io 256");
    rd(3'd4, 8'h18, 32'hFFFF_0008, 1'b0, "R6 BAR2 prefetch 64K");
    rd(3'd4, 8'h1C, 32'h0000_0000, 1'b0, "R6 BAR3 size 0");
    rd(3'd4, 8'h20, 32'hFFFF_FFE1, 1'b0, "R6 BAR4 io 32");
  endtask

  task automatic t_bar_program();
    wr(3'd4, 8'h10, 32'h0002_300F, 1'b0, "R7 BAR0 program");
    rd(3'd4, 8'h10, 32'h0002_3000, 1'b0, "R7 BAR0 low bits kept");
    wr(3'd4, 8'h14, 32'h0000_0402, 1'b0, "R7 BAR1 program");
    rd(3'd4, 8'h14, 32'h0000_0401, 1'b0, "R5 BAR1 io bit kept");
    wr(3'd4, 8'h18, 32'h1234_5677, 1'b0, "R7 BAR2 program");
    rd(3'd4, 8'h18, 32'h1234_5678, 1'b0, "R5 BAR2 type kept");
    wr(3'd1, 8'h10, 32'hAA, 1'b0, "R7 BAR0 byte write");
    wr(3'd2, 8'h12, 32'hBBBB, 1'b0, "R7 BAR0 half write");
    rd(3'd4, 8'h10, 32'h0002_3000, 1'b0, "R7 narrow BAR writes ignored");
  endtask

  task automatic t_rom();
    wr(3'd4, 8'h30, 32'hFFFF_FFFE, 1'b0, "R8 rom size request");
    rd(3'd4, 8'h30, 32'hFFFF_FFFF, 1'b0, "R8 rom all ones");
    wr(3'd4, 8'h30, 32'h000C_0001, 1'b0, "R8 rom plain write");
    rd(3'd4, 8'h30, 32'h000C_0001, 1'b0, "R8 rom stored");
    wr(3'd4, 8'h30, 32'hFFFF_FFFF, 1'b0, "R8 rom ones write");
    rd(3'd4, 8'h30, 32'hFFFF_FFFF, 1'b0, "R8 rom ones stored");
  endtask

  task automatic t_decode();
    dec(32'h4002_3ABC, 6'b000001, 32'h0000_0ABC, "R11 BAR0 inside");
    dec(32'h4002_4000, 6'b000000, 32'h0, "R11 BAR0 past end");
    dec(32'h4002_2FFF, 6'b000000, 32'h0, "R11 BAR0 below base");
    dec(32'h0800_0450, 6'b000010, 32'h0000_0050, "R11 BAR1 io window");
    // BAR2 sized then reprogrammed to 0x12345678: base 0x52345670
    dec(32'h5234_5680, 6'b000100, 32'h0000_0010, "R11 BAR2 window");
    wr(3'd4, 8'h18, 32'h0000_0000, 1'b0, "R11 BAR2 close");
    dec(32'h5234_5680, 6'b000000, 32'h0, "R11 BAR2 closed");
    wr(3'd4, 8'h20, 32'h0000_0400, 1'b0, "R12 BAR4 overlap");
    dec(32'h0800_0410, 6'b000010, 32'h0000_0010, "R12 lowest index wins");
    wr(3'd4, 8'h14, 32'h0000_1000, 1'b0, "R12 BAR1 move");
    dec(32'h0800_0410, 6'b010000, 32'h0000_0010, "R12 BAR4 alone");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_refused();
    t_byte_fields();
    t_command();
    t_bar_sizing();
    t_bar_program();
    t_rom();
    t_decode();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R4 actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule